// File: doc/BRIEF.md
# Serial Register Access Slave

This block is the serial front end of a timekeeping device. An external SPI master (clock idle high, data captured on the rising SCLK edge, launched on the falling edge) sends one command byte, then one or more data bytes. The command selects read or write, the register bank or the scratch RAM, and a 5-bit address. Two addresses are special: address 31 in register space streams the whole clock set plus the control byte, and address 31 in RAM space streams the whole scratch RAM.

The timekeeping core sits beside the block. It presents its live time as a flat vector and receives staged updates as a one-cycle load pulse with a per-register mask. Updates to time registers are held in a shadow buffer and handed over only when chip select is released. A burst read copies the live time into a snapshot when its command byte completes, so every byte of the burst comes from the same instant. A control register carries a write-protect flag. The SPI pins are asynchronous to the system clock and are synchronised inside the block.

Top module: `spi_reg_slave`

## Requirements
- R1: In the command byte, bit 7 selects read (1) or write (0), bit 6 selects RAM (1) or register bank (0), bits 5..1 give the address, and bit 0 must be 1; a write command with bit 0 at 0 changes nothing.
- R2: DIN is captured on rising SCLK and DOUT changes on falling SCLK, MSB first; the first read bit is presented on the first falling edge after the command byte's last rising edge.
- R3: spiDoutEn is 0 while chip select is high and throughout every write transfer.
- R4: A register burst (command 0xBF) returns the seven clock bytes in order seconds, minutes, hours, date, month, weekday, year (tkNow byte 0 first), then the control byte, all taken from one snapshot captured when the command byte completes.
- R5: A register burst write (command 0x3F) stages seven clock bytes and a control byte; after chip select rises with all eight bytes received, tkLoad pulses once with tkMask = 0x7F and tkData holding the staged bytes; a burst with fewer bytes produces no load.
- R6: A single write to register address 0..6 raises tkLoad once after chip select rises, with only that address's tkMask bit set and the byte in tkData lane 8*addr.
- R7: A single write accepts exactly one data byte; any further bytes in the same transfer change nothing.
- R8: Control bit 7 is write protect: while set, writes to RAM and to clock registers are dropped, while writes to the control register (address 7) still apply; control bits 6..0 always read 0.
- R9: A RAM burst write (command 0x7F) stores each completed byte at RAM locations 0, 1, 2 … in turn; a trailing partial byte is discarded. A RAM burst read (command 0xFF) returns locations from 0 upward.
- R10: A RAM burst read drives data for 31 bytes and then drops spiDoutEn; a single read drives one byte and then drops it.
- R11: Register addresses 8..30 read as 0x00 and writes to them have no effect and raise no tkLoad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | Serial clock, idle high, asynchronous |
| spiCsN | input | 1 | Chip select, active low, asynchronous |
| spiDin | input | 1 | Serial data from master |
| spiDout | output | 1 | Serial data to master (0 when not driving) |
| spiDoutEn | output | 1 | Output driver enable for the DOUT pad |
| tkNow | input | 8*CLK_REGS | Live time from the core, byte 0 = seconds |
| tkLoad | output | 1 | One-cycle pulse handing staged bytes to the core |
| tkMask | output | CLK_REGS | Which staged bytes the load applies to |
| tkData | output | 8*CLK_REGS | Staged clock bytes, byte 0 = seconds |

## Verification
Every SPI pin change reaches the logic through two synchroniser stages and one register, so a DOUT or enable change is due three system cycles after the SCLK or chip-select edge that causes it. The bench holds each SCLK level for eight cycles and samples DOUT and its enable on the last cycle before each rising edge, well past that latency. A load to the core is due two cycles after the synchronised chip-select rise; the bench checks that no load has occurred just before releasing chip select and reads the captured load thirty-two cycles after it, when any pulse must have come and gone.

// File: rtl/spi_reg_pkg.sv
`timescale 1ns/1ps
package spi_reg_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  // strobes from the sequencer to the datapath, valid for one cycle
  typedef struct packed {
    logic       dinBit;
    logic       shiftIn;
    logic       snap;
    logic       ramWr;
    logic       shadowWr;
    logic       ctrlWr;
    logic       ctrlStage;
    logic       commit;
    logic       discard;
    logic       txLoad;
    logic       txShift;
    logic       rdRam;
    logic [4:0] idx;
  } strobe_t;

endpackage

// File: rtl/spi_reg_ctrl.sv
`timescale 1ns/1ps
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int RAM_DEPTH   = 31,
  parameter int CLK_REGS    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSclk,
  input  logic       spiCsN,
  input  logic       spiDin,
  input  logic [7:0] rxNext,
  input  logic       wpState,
  output strobe_t    stb,
  output logic       doutOe,
  output logic       csActive
);

  localparam logic [5:0] RAM_LEN   = 6'(RAM_DEPTH);
  localparam logic [5:0] CLK_CNT   = 6'(CLK_REGS);
  localparam logic [5:0] BURST_LEN = 6'(CLK_REGS + 1);
  localparam logic [4:0] RAM_LIM   = 5'(RAM_DEPTH);
  localparam logic [4:0] CLK_LIM   = 5'(CLK_REGS);
  localparam logic [4:0] CTRL_ADDR = 5'(CLK_REGS);
  localparam logic [4:0] BURST_ADDR = 5'h1F;

  logic [SYNC_STAGES-1:0] sclkSync, csSync, dinSync;
  logic sclkS, csS, dinS, sclkD, csD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '1;
      csSync   <= '1;
      dinSync  <= '0;
      sclkD    <= 1'b1;
      csD      <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], spiSclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], spiCsN};
      dinSync  <= {dinSync[SYNC_STAGES-2:0], spiDin};
      sclkD    <= sclkS;
      csD      <= csS;
    end
  end

  assign sclkS    = sclkSync[SYNC_STAGES-1];
  assign csS      = csSync[SYNC_STAGES-1];
  assign dinS     = dinSync[SYNC_STAGES-1];
  assign csActive = ~csS;

  phase_e     phase;
  logic [2:0] bitCnt;
  logic [5:0] byteCnt;
  logic       isRead, isRam, txPend;
  logic [4:0] addr;

  logic sclkRise, sclkFall, csRise, byteDone, isBurst, clkBurstWr;
  logic [5:0] rdLimit;

  assign sclkRise   = sclkS & ~sclkD & csActive;
  assign sclkFall   = ~sclkS & sclkD & csActive;
  assign csRise     = csS & ~csD;
  assign byteDone   = sclkRise && (bitCnt == 3'd7);
  assign isBurst    = (addr == BURST_ADDR);
  assign clkBurstWr = !isRead && !isRam && isBurst && (phase != PH_CMD);
  assign rdLimit    = !isBurst ? 6'd1 : (isRam ? RAM_LEN : BURST_LEN);

  always_comb begin
    stb         = '0;
    stb.dinBit  = dinS;
    stb.shiftIn = sclkRise;
    stb.rdRam   = isRam;
    stb.idx     = isBurst ? byteCnt[4:0] : addr;
    stb.snap    = (phase == PH_CMD) && byteDone && rxNext[7];
    stb.txLoad  = sclkFall && txPend && (byteCnt < rdLimit);
    stb.txShift = sclkFall && !txPend && doutOe;
    stb.commit  = csRise && !(clkBurstWr && (byteCnt < BURST_LEN));
    stb.discard = csRise && !stb.commit;
    if ((phase == PH_DATA) && byteDone && !isRead) begin
      if (isRam) begin
        if (isBurst ? (byteCnt < RAM_LEN) : (addr < RAM_LIM))
          stb.ramWr = !wpState;
      end else if (isBurst) begin
        if (byteCnt < CLK_CNT)       stb.shadowWr  = !wpState;
        else if (byteCnt == CLK_CNT) stb.ctrlStage = 1'b1;
      end else begin
        if (addr < CLK_LIM)          stb.shadowWr = !wpState;
        else if (addr == CTRL_ADDR)  stb.ctrlWr   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      byteCnt <= '0;
      isRead  <= 1'b0;
      isRam   <= 1'b0;
      addr    <= '0;
      txPend  <= 1'b0;
      doutOe  <= 1'b0;
    end else if (!csActive) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      byteCnt <= '0;
      txPend  <= 1'b0;
      doutOe  <= 1'b0;
    end else begin
      if (sclkRise) begin
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          unique case (phase)
            PH_CMD: begin
              isRead <= rxNext[7];
              isRam  <= rxNext[6];
              addr   <= rxNext[5:1];
              txPend <= rxNext[7];
              phase  <= (!rxNext[7] && !rxNext[0]) ? PH_DONE : PH_DATA;
            end
            PH_DATA: begin
              if (byteCnt != 6'h3F) byteCnt <= byteCnt + 6'd1;
              if (isRead) txPend <= 1'b1;
              else if (!isBurst) phase <= PH_DONE;
            end
            default: ;
          endcase
        end
      end
      if (sclkFall && txPend) begin
        txPend <= 1'b0;
        doutOe <= (byteCnt < rdLimit);
      end
    end
  end

endmodule

// File: rtl/spi_reg_dp.sv
`timescale 1ns/1ps
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int RAM_DEPTH = 31,
  parameter int CLK_REGS  = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [8*CLK_REGS-1:0] tkNow,
  output logic [7:0]            rxNext,
  output logic                  wpState,
  output logic                  doutBit,
  output logic                  tkLoad,
  output logic [CLK_REGS-1:0]   tkMask,
  output logic [8*CLK_REGS-1:0] tkData
);

  localparam int RAM_IDX_W = $clog2(RAM_DEPTH);
  localparam int CLK_IDX_W = $clog2(CLK_REGS);
  localparam logic [4:0] RAM_LIM   = 5'(RAM_DEPTH);
  localparam logic [4:0] CLK_LIM   = 5'(CLK_REGS);
  localparam logic [4:0] CTRL_ADDR = 5'(CLK_REGS);

  logic [7:0] rxShift, txReg, rdByte;
  logic [7:0] ram [RAM_DEPTH];
  logic [CLK_REGS-1:0]   maskVec;
  logic [8*CLK_REGS-1:0] snapFlat;
  logic ctrlStaged, ctrlStageVal;

  assign rxNext = {rxShift[6:0], stb.dinBit};

  for (genvar i = 0; i < CLK_REGS; i++) begin : g_clk
    logic [7:0] shadowReg, snapReg;
    logic       pendBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowReg <= '0;
        snapReg   <= '0;
        pendBit   <= 1'b0;
      end else begin
        if (stb.snap) snapReg <= tkNow[8*i +: 8];
        if (stb.commit || stb.discard) pendBit <= 1'b0;
        else if (stb.shadowWr && (stb.idx == 5'(i))) begin
          shadowReg <= rxNext;
          pendBit   <= 1'b1;
        end
      end
    end
    assign maskVec[i]          = pendBit;
    assign snapFlat[8*i +: 8]  = snapReg;
    assign tkData[8*i +: 8]    = shadowReg;
  end

  always_ff @(posedge clk) begin
    if (stb.ramWr) ram[stb.idx[RAM_IDX_W-1:0]] <= rxNext;
  end

  always_comb begin
    rdByte = 8'h00;
    if (stb.rdRam) begin
      if (stb.idx < RAM_LIM) rdByte = ram[stb.idx[RAM_IDX_W-1:0]];
    end else if (stb.idx < CLK_LIM) begin
      rdByte = snapFlat[8*stb.idx[CLK_IDX_W-1:0] +: 8];
    end else if (stb.idx == CTRL_ADDR) begin
      rdByte = {wpState, 7'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift      <= '0;
      txReg        <= '0;
      doutBit      <= 1'b0;
      wpState      <= 1'b0;
      ctrlStaged   <= 1'b0;
      ctrlStageVal <= 1'b0;
      tkLoad       <= 1'b0;
      tkMask       <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= rxNext;
      if (stb.txLoad) begin
        doutBit <= rdByte[7];
        txReg   <= {rdByte[6:0], 1'b0};
      end else if (stb.txShift) begin
        doutBit <= txReg[7];
        txReg   <= {txReg[6:0], 1'b0};
      end
      tkLoad <= stb.commit && (|maskVec);
      if (stb.commit) tkMask <= maskVec;
      if (stb.ctrlWr) wpState <= rxNext[7];
      else if (stb.commit && ctrlStaged) wpState <= ctrlStageVal;
      if (stb.commit || stb.discard) ctrlStaged <= 1'b0;
      else if (stb.ctrlStage) begin
        ctrlStaged   <= 1'b1;
        ctrlStageVal <= rxNext[7];
      end
    end
  end

endmodule

// File: rtl/spi_reg_slave.sv
`timescale 1ns/1ps
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int RAM_DEPTH   = 31,
  parameter int CLK_REGS    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  spiSclk,
  input  logic                  spiCsN,
  input  logic                  spiDin,
  output logic                  spiDout,
  output logic                  spiDoutEn,
  input  logic [8*CLK_REGS-1:0] tkNow,
  output logic                  tkLoad,
  output logic [CLK_REGS-1:0]   tkMask,
  output logic [8*CLK_REGS-1:0] tkData
);

  strobe_t    stb;
  logic [7:0] rxNext;
  logic       wpState, doutBit, csActive;

  spi_reg_ctrl #(
    .RAM_DEPTH(RAM_DEPTH), .CLK_REGS(CLK_REGS), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiDin(spiDin),
    .rxNext(rxNext), .wpState(wpState), .stb(stb), .doutOe(spiDoutEn),
    .csActive(csActive)
  );

  spi_reg_dp #(
    .RAM_DEPTH(RAM_DEPTH), .CLK_REGS(CLK_REGS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tkNow(tkNow), .rxNext(rxNext),
    .wpState(wpState), .doutBit(doutBit), .tkLoad(tkLoad), .tkMask(tkMask),
    .tkData(tkData)
  );

  assign spiDout = doutBit & spiDoutEn;

endmodule

// File: rtl/spi_reg_checker.sv
`timescale 1ns/1ps
module spi_reg_checker (
  input logic clk,
  input logic rstN,
  input logic csActive,
  input logic doutEn,
  input logic tkLoad,
  input logic ramWr,
  input logic shadowWr,
  input logic ctrlWr,
  input logic ctrlStage,
  input logic wpState
);

  p_dout_off_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !doutEn);

  p_load_after_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    tkLoad |-> !$past(csActive));

  p_wp_ram_r8: assert property (@(posedge clk) disable iff (!rstN)
    ramWr |-> !wpState);

  p_wp_shadow_r8: assert property (@(posedge clk) disable iff (!rstN)
    shadowWr |-> !wpState);

  p_single_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramWr, shadowWr, ctrlWr, ctrlStage}));

endmodule

bind spi_reg_slave spi_reg_checker u_chk (
  .clk(clk), .rstN(rstN), .csActive(csActive), .doutEn(spiDoutEn),
  .tkLoad(tkLoad), .ramWr(stb.ramWr), .shadowWr(stb.shadowWr),
  .ctrlWr(stb.ctrlWr), .ctrlStage(stb.ctrlStage), .wpState(wpState)
);

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb;

  localparam int HALF  = 8;
  localparam int RAM_N = 31;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        spiSclk = 1'b1, spiCsN = 1'b1, spiDin = 1'b0;
  logic        spiDout, spiDoutEn, tkLoad;
  logic [55:0] tkNow = '0, tkData;
  logic [6:0]  tkMask;

  spi_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiDin(spiDin),
    .spiDout(spiDout), .spiDoutEn(spiDoutEn), .tkNow(tkNow), .tkLoad(tkLoad),
    .tkMask(tkMask), .tkData(tkData)
  );

  int          nChk = 0, nFail = 0, loadCnt = 0;
  logic [6:0]  lastMask = '0;
  logic [55:0] lastData = '0;
  logic [7:0]  ramModel [RAM_N];
  bit          done = 0;

  always @(negedge clk) begin
    if (rstN && tkLoad) begin
      loadCnt++;
      lastMask = tkMask;
      lastData = tkData;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBits(input logic [7:0] tx, input int nb,
                         output logic [7:0] rx, output logic oeSeen);
    rx = '0;
    oeSeen = 1'b0;
    for (int b = 7; b >= 8 - nb; b--) begin
      spiSclk = 1'b0;
      spiDin  = tx[b];
      waitCyc(HALF);
      rx[b]  = spiDout;
      oeSeen = oeSeen | spiDoutEn;
      spiSclk = 1'b1;
      waitCyc(HALF);
    end
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx, output logic oeSeen);
    spiBits(tx, 8, rx, oeSeen);
  endtask

  task automatic spiBegin();
    spiCsN = 1'b0;
    waitCyc(HALF);
  endtask

  task automatic spiEnd();
    waitCyc(HALF);
    spiCsN = 1'b1;
    waitCyc(4 * HALF);
  endtask

  // single read: returns data byte, whether it was driven, and enable during a trailing byte
  task automatic xRead(input logic [7:0] cmd, output logic [7:0] d,
                       output logic oeData, output logic oeAfter);
    logic [7:0] rx;
    logic oe;
    spiBegin();
    spiByte(cmd, rx, oe);
    spiByte(8'h00, d, oeData);
    spiByte(8'h00, rx, oeAfter);
    spiEnd();
  endtask

  // single write with optional extra trailing byte; returns whether DOUT was ever driven
  task automatic xWrite(input logic [7:0] cmd, input logic [7:0] d,
                        input bit extra, input logic [7:0] d2, output logic oeAny);
    logic [7:0] rx;
    logic oe;
    spiBegin();
    spiByte(cmd, rx, oe);
    oeAny = oe;
    spiByte(d, rx, oe);
    oeAny |= oe;
    if (extra) begin
      spiByte(d2, rx, oe);
      oeAny |= oe;
    end
    spiEnd();
  endtask

  function automatic logic [7:0] ramRdCmd(input int a);
    return {2'b11, 5'(a), 1'b1};
  endfunction
  function automatic logic [7:0] ramWrCmd(input int a);
    return {2'b01, 5'(a), 1'b1};
  endfunction
  function automatic logic [7:0] regWrCmd(input int a);
    return {2'b00, 5'(a), 1'b1};
  endfunction
  function automatic logic [7:0] regRdCmd(input int a);
    return {2'b10, 5'(a), 1'b1};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  rx, d, d2;
    logic        oe, oeA, oeB, oeAny;
    logic [55:0] oldTime, burstTime;
    logic [7:0]  burstBytes [7];
    int          mism, base, k;

    void'($urandom(32'd20240611));
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    chk("R3 enable after reset", 64'(spiDoutEn), 64'd0);
    chk("R5 no load after reset", 64'(tkLoad), 64'd0);
    tkNow = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;

    // R9 full RAM burst write, R3 no drive during writes
    oeAny = 1'b0;
    spiBegin();
    spiByte(8'h7F, rx, oe);
    oeAny |= oe;
    for (int i = 0; i < RAM_N; i++) begin
      d = 8'($urandom);
      ramModel[i] = d;
      spiByte(d, rx, oe);
      oeAny |= oe;
    end
    spiEnd();
    chk("R3 enable during RAM burst write", 64'(oeAny), 64'd0);

    // R9 burst readback, R10 enable drops after 31 bytes, R2 bit ordering
    mism = 0;
    spiBegin();
    spiByte(8'hFF, rx, oe);
    chk("R3 enable during command byte", 64'(oe), 64'd0);
    for (int i = 0; i < RAM_N; i++) begin
      spiByte(8'h00, rx, oe);
      if (rx !== ramModel[i] || oe !== 1'b1) mism++;
    end
    spiByte(8'h00, rx, oe);
    spiEnd();
    chk("R9 RAM burst readback mismatches", 64'(mism), 64'd0);
    chk("R10 enable after 31 RAM bytes", 64'(oe), 64'd0);

    // R9 partial burst: k whole bytes then a half byte
    k = 1 + int'($urandom % 6);
    d2 = ~ramModel[k];
    spiBegin();
    spiByte(8'h7F, rx, oe);
    for (int i = 0; i < k; i++) begin
      d = 8'($urandom);
      ramModel[i] = d;
      spiByte(d, rx, oe);
    end
    spiBits(d2, 4, rx, oe);
    spiEnd();
    mism = 0;
    for (int i = 0; i <= k; i++) begin
      xRead(ramRdCmd(i), rx, oeA, oeB);
      if (rx !== ramModel[i]) mism++;
    end
    chk("R9 partial burst keeps whole bytes only", 64'(mism), 64'd0);
    chk("R10 single read enable drops after one byte", 64'(oeB), 64'd0);
    chk("R2 single read data driven", 64'(oeA), 64'd1);

    // R1 write command with bit 0 clear is ignored
    spiBegin();
    spiByte(8'h44, rx, oe);
    spiByte(~ramModel[2], rx, oe);
    spiEnd();
    xRead(ramRdCmd(2), rx, oeA, oeB);
    chk("R1 write with bit0=0 ignored", 64'(rx), 64'(ramModel[2]));

    // R7 single write ignores the second byte
    d = 8'($urandom);
    d2 = ~ramModel[4];
    xWrite(ramWrCmd(3), d, 1'b1, d2, oeAny);
    ramModel[3] = d;
    chk("R3 enable during single write", 64'(oeAny), 64'd0);
    xRead(ramRdCmd(3), rx, oeA, oeB);
    chk("R7 first byte stored", 64'(rx), 64'(d));
    xRead(ramRdCmd(4), rx, oeA, oeB);
    chk("R7 extra byte ignored", 64'(rx), 64'(ramModel[4]));

    // R5 full clock burst write
    base = loadCnt;
    burstTime = '0;
    spiBegin();
    spiByte(8'h3F, rx, oe);
    for (int i = 0; i < 7; i++) begin
      d = 8'($urandom);
      burstTime[8*i +: 8] = d;
      spiByte(d, rx, oe);
    end
    spiByte(8'h00, rx, oe);
    waitCyc(HALF);
    chk("R5 no load before CS rise", 64'(loadCnt), 64'(base));
    spiEnd();
    chk("R5 one load after burst", 64'(loadCnt), 64'(base + 1));
    chk("R5 burst mask", 64'(lastMask), 64'h7F);
    chk("R5 burst data order", 64'(lastData), 64'(burstTime));

    // R5 incomplete clock burst discarded
    base = loadCnt;
    spiBegin();
    spiByte(8'h3F, rx, oe);
    for (int i = 0; i < 5; i++) spiByte(8'($urandom), rx, oe);
    spiEnd();
    chk("R5 short burst gives no load", 64'(loadCnt), 64'(base));

    // R6 single write to minutes (address 1)
    base = loadCnt;
    d = 8'($urandom);
    xWrite(regWrCmd(1), d, 1'b0, 8'h00, oeAny);
    chk("R6 single clock write loads", 64'(loadCnt), 64'(base + 1));
    chk("R6 single clock write mask", 64'(lastMask), 64'h02);
    chk("R6 single clock write lane", 64'(lastData[15:8]), 64'(d));

    // R4 burst read from a snapshot while the live time moves
    oldTime = tkNow;
    mism = 0;
    spiBegin();
    spiByte(8'hBF, rx, oe);
    spiByte(8'h00, burstBytes[0], oe);
    tkNow = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
    for (int i = 1; i < 7; i++) spiByte(8'h00, burstBytes[i], oe);
    for (int i = 0; i < 7; i++) if (burstBytes[i] !== oldTime[8*i +: 8]) mism++;
    spiByte(8'h00, rx, oe);
    spiEnd();
    chk("R4 burst read snapshot bytes", 64'(mism), 64'd0);
    chk("R4 burst read control byte", 64'(rx), 64'h00);

    // R11 unused register address
    xRead(regRdCmd(10), rx, oeA, oeB);
    chk("R11 unused register reads zero", 64'(rx), 64'h00);
    base = loadCnt;
    xWrite(regWrCmd(10), 8'hA5, 1'b0, 8'h00, oeAny);
    chk("R11 write to unused register no load", 64'(loadCnt), 64'(base));
    xRead(regRdCmd(10), rx, oeA, oeB);
    chk("R11 unused register still zero", 64'(rx), 64'h00);

    // R8 write protect
    xWrite(regWrCmd(7), 8'h80, 1'b0, 8'h00, oeAny);
    xRead(regRdCmd(7), rx, oeA, oeB);
    chk("R8 control reads protect set", 64'(rx), 64'h80);
    xWrite(ramWrCmd(6), ~ramModel[6], 1'b0, 8'h00, oeAny);
    xRead(ramRdCmd(6), rx, oeA, oeB);
    chk("R8 RAM write blocked", 64'(rx), 64'(ramModel[6]));
    base = loadCnt;
    xWrite(regWrCmd(2), 8'h12, 1'b0, 8'h00, oeAny);
    chk("R8 clock write blocked", 64'(loadCnt), 64'(base));
    xWrite(regWrCmd(7), 8'h7F, 1'b0, 8'h00, oeAny);
    xRead(regRdCmd(7), rx, oeA, oeB);
    chk("R8 control cleared, low bits read zero", 64'(rx), 64'h00);
    d = ~ramModel[6];
    xWrite(ramWrCmd(6), d, 1'b0, 8'h00, oeAny);
    ramModel[6] = d;
    xRead(ramRdCmd(6), rx, oeA, oeB);
    chk("R8 RAM write allowed again", 64'(rx), 64'(d));

    // random single RAM accesses against the model (R1, R2)
    mism = 0;
    for (int it = 0; it < 12; it++) begin
      int a, b;
      a = int'($urandom % RAM_N);
      b = int'($urandom % RAM_N);
      d = 8'($urandom);
      xWrite(ramWrCmd(a), d, 1'b0, 8'h00, oeAny);
      ramModel[a] = d;
      xRead(ramRdCmd(b), rx, oeA, oeB);
      if (rx !== ramModel[b]) mism++;
    end
    chk("R1 random single RAM accesses", 64'(mism), 64'd0);

    done = 1;
    summary();
    $finish;
  end

endmodule